// File: doc/BRIEF.md
# Termination Regulator Power-Mode Supervisor

This block is the digital supervisor of a memory bus termination regulator. It samples two active-low host controls (a power-off request and a suspend request), a flag from the internal supply that says its power-on reset has been released, and five fault flags from analog comparators: overcurrent, short circuit, over-temperature, output undervoltage and output overvoltage. From these it decides which power mode the regulator is in. It drives enables for the internal bias, the reference buffer, the switching converter and its soft-start ramp, a high-impedance control for the main output, and discharge switches for both the termination rail and the reference rail. It also drives an active-low power-good output for the host.

All asynchronous inputs pass through a two-flop synchronizer. A free-running prescaler divides the fast system clock into a slow tick. The soft-start length, power-good delay, overcurrent persistence and hiccup retry period are counted in ticks. The undervoltage and overvoltage glitch filter is counted in system clocks. The power-off request always wins over the suspend request. Suspend keeps the reference rail alive while the main output floats. Converter faults lead to a hiccup cycle: the converter is switched off, a retry period runs, and then a fresh soft start begins.

Top module: `ddrvtt_supervisor`

## Requirements
- R1: While `shdn_n` is low, the outputs are `dis_tt_en`=1 and `dis_ref_en`=1, and `bias_en`, `refbuf_en`, `conv_en` and `ss_en` are all 0, and `pgood_n`=1. This holds whatever `stby_n` is, and it is reached within 3 clocks of `shdn_n` going low. It is also the state after reset.
- R2: `dis_tt_en` and `dis_ref_en` are 1 only in the shutdown mode. They are 0 in every other mode.
- R3: With `shdn_n`=1, `por_ok`=1 and `stby_n`=0, the block is in standby. In standby `bias_en`=1, `refbuf_en`=1, `out_hiz`=1, `conv_en`=0 and `pgood_n`=1.
- R4: With both controls high but `por_ok`=0, only `bias_en` is 1. `refbuf_en`, `conv_en` and `ss_en` stay 0, and no ramp starts.
- R5: When both controls and `por_ok` are high, the block enters a soft start. In soft start `ss_en`=1 and `conv_en`=1 for SS_TICKS ticks. Then `ss_en` falls and `conv_en` stays 1.
- R6: `pgood_n` goes low PG_TICKS ticks after the soft start ends, and not before. Any exit from normal mode raises it at once, and the delay starts again on the next entry.
- R7: An overcurrent flag that persists for OC_TICKS ticks turns the converter off. A shorter pulse has no effect on `conv_en` or `pgood_n`.
- R8: After a converter fault, `conv_en` stays 0 for RETRY_TICKS ticks. Then a new soft start begins.
- R9: A short-circuit flag turns `conv_en` off within 3 clocks, with no persistence wait. It then follows the retry of R8.
- R10: An over-temperature flag turns `conv_en` off within 3 clocks. It then follows the retry of R8.
- R11: An undervoltage or overvoltage flag that persists for FILT_CYC clocks raises `pgood_n` but leaves `conv_en` at 1. A shorter glitch is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shdn_n | input | 1 | Power-off request, active low (asynchronous) |
| stby_n | input | 1 | Suspend request, active low (asynchronous) |
| por_ok | input | 1 | Internal supply out of power-on reset (asynchronous) |
| oc_flag | input | 1 | Overcurrent comparator |
| sc_flag | input | 1 | Short-circuit comparator |
| ot_flag | input | 1 | Over-temperature comparator |
| uv_flag | input | 1 | Output undervoltage comparator |
| ov_flag | input | 1 | Output overvoltage comparator |
| bias_en | output | 1 | Internal supply and bias enable |
| refbuf_en | output | 1 | Reference buffer enable |
| conv_en | output | 1 | Switching converter enable |
| ss_en | output | 1 | Soft-start ramp running |
| out_hiz | output | 1 | Main output placed in high impedance |
| dis_tt_en | output | 1 | Termination rail discharge switch |
| dis_ref_en | output | 1 | Reference rail discharge switch |
| pgood_n | output | 1 | Power good, active low |

## Verification
The bench targets four groups of cases. The first is the precedence of power-off over suspend: a design that let suspend win would leave the reference buffer on with the discharge switches off. The second is the persistence windows. Overcurrent and undervoltage pulses shorter than their windows must leave the converter and power-good untouched, while held flags must act. A design that skipped a filter would drop the converter or power-good on a glitch. The third is the timed windows of soft start, power-good delay and hiccup retry, each sampled just before and just after the expected edge. A counter that was off by a tick or never restarted would show up there. The fourth is the fault paths: short circuit and over-temperature must act within the synchronizer latency, and undervoltage must clear power-good while the converter stays on.

// File: rtl/ddrvtt_sup_pkg.sv
// Package: shared mode type for the termination regulator supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package ddrvtt_sup_pkg;

    typedef enum logic [2:0] {
        PM_OFF    = 3'd0,   // power-off, rails discharged
        PM_BIAS   = 3'd1,   // bias only, waiting on supply reset
        PM_STBY   = 3'd2,   // suspend, reference alive, output floating
        PM_RAMP   = 3'd3,   // converter on, soft start running
        PM_RUN    = 3'd4,   // normal regulation
        PM_HICCUP = 3'd5    // converter off after fault, retry pending
    } pmode_t;

    // Larger of two counts, used to size shared timers.
    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddrvtt_sup_sync.sv
// Two-flop synchronizer for a bus of independent asynchronous flags.
// Assumes: each bit is a level that is held for more than one clock;
// bits are not related to each other after synchronization.
module ddrvtt_sup_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;

    // Two register stages; reset clears both to a safe all-zero value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/ddrvtt_sup_tick.sv
// Free-running prescaler: one-cycle tick every DIV system clocks.
// Assumes: DIV >= 2.
module ddrvtt_sup_tick #(
    parameter int unsigned DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    // Count 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)             div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + CW'(1);
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/ddrvtt_sup_persist.sv
// Persistence filter: hit rises once flag has been high for LIMIT steps
// while armed; dropping flag or arm clears the count.
// Assumes: LIMIT >= 1; step is a single-cycle strobe or constant 1.
module ddrvtt_sup_persist #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic step,
    input  logic flag,
    output logic hit
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    logic [W-1:0] cnt_q;

    // Accumulate steps while flag persists; saturate at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (!flag || !arm)       cnt_q <= '0;
        else if (step && cnt_q != TOP) cnt_q <= cnt_q + W'(1);
    end

    assign hit = (cnt_q == TOP);

    // A qualified fault needs the raw flag to have been present (R7, R11).
    assert_hit_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(flag));
endmodule

// File: rtl/ddrvtt_supervisor.sv
// Power-mode and fault supervisor for a memory termination regulator.
// Arbitrates power-off / suspend / normal modes, sequences soft start,
// qualifies faults, runs the hiccup retry and the power-good delay.
// Assumes: all flag inputs are asynchronous levels; timed windows are
// counted in prescaled ticks except the UV/OV filter (system clocks).
module ddrvtt_supervisor #(
    parameter int unsigned TICK_DIV    = 250,     // clocks per tick
    parameter int unsigned SS_TICKS    = 2000,    // soft-start length
    parameter int unsigned PG_TICKS    = 10000,   // power-good delay
    parameter int unsigned OC_TICKS    = 10000,   // overcurrent persistence
    parameter int unsigned RETRY_TICKS = 100000,  // hiccup retry period
    parameter int unsigned FILT_CYC    = 3750     // UV/OV glitch filter
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shdn_n,
    input  logic stby_n,
    input  logic por_ok,
    input  logic oc_flag,
    input  logic sc_flag,
    input  logic ot_flag,
    input  logic uv_flag,
    input  logic ov_flag,
    output logic bias_en,
    output logic refbuf_en,
    output logic conv_en,
    output logic ss_en,
    output logic out_hiz,
    output logic dis_tt_en,
    output logic dis_ref_en,
    output logic pgood_n
);
    import ddrvtt_sup_pkg::*;

    localparam int unsigned NIN  = 8;
    localparam int unsigned TMAX = max2(max2(SS_TICKS, PG_TICKS), RETRY_TICKS);
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] SS_L    = TW'(SS_TICKS);
    localparam logic [TW-1:0] PG_L    = TW'(PG_TICKS);
    localparam logic [TW-1:0] RETRY_L = TW'(RETRY_TICKS);

    logic [NIN-1:0] raw, syn;
    logic shdn_s, stby_s, por_s, oc_s, sc_s, ot_s, uv_s, ov_s;
    logic tick, oc_hit, trip;
    logic [1:0] vflag, vhit;
    pmode_t st_q, st_d;
    logic [TW-1:0] tmr_q, tmr_lim;

    assign raw = {shdn_n, stby_n, por_ok, oc_flag, sc_flag, ot_flag, uv_flag, ov_flag};

    ddrvtt_sup_sync #(.WIDTH(NIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(raw), .sync_out(syn)
    );

    assign {shdn_s, stby_s, por_s, oc_s, sc_s, ot_s, uv_s, ov_s} = syn;

    ddrvtt_sup_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    // Overcurrent persistence, counted in ticks while the converter runs.
    ddrvtt_sup_persist #(.LIMIT(OC_TICKS)) u_oc_filt (
        .clk(clk), .rst_n(rst_n), .arm(conv_en), .step(tick),
        .flag(oc_s), .hit(oc_hit)
    );

    // Output window filters (UV, OV), counted in clocks while in normal mode.
    assign vflag = {uv_s, ov_s};
    for (genvar g = 0; g < 2; g++) begin : g_vwin
        ddrvtt_sup_persist #(.LIMIT(FILT_CYC)) u_vfilt (
            .clk(clk), .rst_n(rst_n), .arm(st_q == PM_RUN), .step(1'b1),
            .flag(vflag[g]), .hit(vhit[g])
        );
    end

    // Converter faults that force a hiccup.
    assign trip = sc_s | ot_s | oc_hit;

    // Timer limit for the current mode.
    always_comb begin
        case (st_q)
            PM_RAMP:   tmr_lim = SS_L;
            PM_RUN:    tmr_lim = PG_L;
            PM_HICCUP: tmr_lim = RETRY_L;
            default:   tmr_lim = '0;
        endcase
    end

    // Mode arbitration: power-off, supply reset, suspend, then sequencing.
    always_comb begin
        st_d = st_q;
        if (!shdn_s)      st_d = PM_OFF;
        else if (!por_s)  st_d = PM_BIAS;
        else if (!stby_s) st_d = PM_STBY;
        else begin
            case (st_q)
                PM_RAMP:   if (trip) st_d = PM_HICCUP;
                           else if (tmr_q == SS_L) st_d = PM_RUN;
                PM_RUN:    if (trip) st_d = PM_HICCUP;
                PM_HICCUP: if (tmr_q == RETRY_L) st_d = PM_RAMP;
                default:   st_d = PM_RAMP;
            endcase
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PM_OFF;
        else        st_q <= st_d;
    end

    // Shared mode timer: cleared on every mode change, saturates at limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                      tmr_q <= '0;
        else if (st_d != st_q)           tmr_q <= '0;
        else if (tick && tmr_q < tmr_lim) tmr_q <= tmr_q + TW'(1);
    end

    // Output decode from the registered mode.
    always_comb begin
        bias_en    = (st_q != PM_OFF);
        refbuf_en  = (st_q == PM_STBY) || (st_q == PM_RAMP) ||
                     (st_q == PM_RUN)  || (st_q == PM_HICCUP);
        conv_en    = (st_q == PM_RAMP) || (st_q == PM_RUN);
        ss_en      = (st_q == PM_RAMP);
        out_hiz    = (st_q == PM_BIAS) || (st_q == PM_STBY) || (st_q == PM_HICCUP);
        dis_tt_en  = (st_q == PM_OFF);
        dis_ref_en = (st_q == PM_OFF);
        pgood_n    = !((st_q == PM_RUN) && (tmr_q == PG_L) && (vhit == 2'b00));
    end

    // Power-off wins over everything one clock after it is synchronized.
    assert_shdn_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_s |=> (dis_tt_en && dis_ref_en && !conv_en && !refbuf_en && pgood_n));

    // Discharge switches never overlap any powered function.
    assert_discharge_only_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_tt_en || dis_ref_en) |-> (!bias_en && !refbuf_en && !conv_en && !out_hiz));

    // Suspend keeps the reference while the output floats.
    assert_stby_keeps_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_s && por_s && !stby_s) |=> (refbuf_en && out_hiz && !conv_en));

    // Power good only with the converter regulating after soft start.
    assert_pg_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pgood_n |-> (conv_en && !ss_en));

    // Short circuit stops the converter on the next clock.
    assert_sc_immediate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_s && stby_s && por_s && sc_s && conv_en) |=> !conv_en);
endmodule

// File: tb/ddrvtt_supervisor_bench.sv
module ddrvtt_supervisor_bench;
    localparam int DIV = 4, SS = 10, PG = 20, OC = 8, RT = 30, FC = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic shdn_n = 1'b1, stby_n = 1'b1, por_ok = 1'b0;
    logic oc_flag = 0, sc_flag = 0, ot_flag = 0, uv_flag = 0, ov_flag = 0;
    logic bias_en, refbuf_en, conv_en, ss_en, out_hiz, dis_tt_en, dis_ref_en, pgood_n;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ddrvtt_supervisor #(.TICK_DIV(DIV), .SS_TICKS(SS), .PG_TICKS(PG), .OC_TICKS(OC),
                        .RETRY_TICKS(RT), .FILT_CYC(FC)) u_ddrvtt_supervisor (
        .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .stby_n(stby_n), .por_ok(por_ok),
        .oc_flag(oc_flag), .sc_flag(sc_flag), .ot_flag(ot_flag), .uv_flag(uv_flag),
        .ov_flag(ov_flag), .bias_en(bias_en), .refbuf_en(refbuf_en), .conv_en(conv_en),
        .ss_en(ss_en), .out_hiz(out_hiz), .dis_tt_en(dis_tt_en), .dis_ref_en(dis_ref_en),
        .pgood_n(pgood_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic pick(input int s);
        case (s)
            0: return conv_en;
            1: return ss_en;
            default: return pgood_n;
        endcase
    endfunction

    // Wait until selected output equals val; n returns clocks waited.
    task automatic wait_sig(input int s, input logic val, input int maxc, output int n);
        n = 0;
        while (pick(s) !== val && n < maxc) begin
            @(negedge clk);
            n++;
        end
    endtask

    // From any converter-on state, wait for soft start to end and PG delay.
    task automatic bring_up(input string req);
        int n;
        wait_sig(1, 1'b0, 200, n);
        cyc(PG * DIV + 4);
        chk(req, "pgood_n after restart", pgood_n, 0);
    endtask

    task automatic t_reset();
        cyc(1);
        chk("R1", "reset dis_tt_en", dis_tt_en, 1);
        chk("R1", "reset dis_ref_en", dis_ref_en, 1);
        chk("R1", "reset conv_en", conv_en, 0);
        chk("R1", "reset pgood_n", pgood_n, 1);
    endtask

    task automatic t_por_gate();
        cyc(8);
        chk("R4", "por low bias_en", bias_en, 1);
        chk("R4", "por low refbuf_en", refbuf_en, 0);
        chk("R4", "por low conv_en", conv_en, 0);
        chk("R4", "por low ss_en", ss_en, 0);
        chk("R2", "por low dis_tt_en", dis_tt_en, 0);
    endtask

    task automatic t_startup();
        int n;
        por_ok = 1'b1;
        wait_sig(1, 1'b1, 10, n);
        chk("R5", "ss_en rise within 4", int'(n <= 4), 1);
        chk("R5", "conv_en in ramp", conv_en, 1);
        wait_sig(1, 1'b0, 80, n);
        chk("R5", "ramp length in window", int'(n >= (SS - 1) * DIV - 2 && n <= SS * DIV + 4), 1);
        chk("R5", "conv_en after ramp", conv_en, 1);
        cyc(PG * DIV - 8);
        chk("R6", "pgood_n before delay", pgood_n, 1);
        cyc(10);
        chk("R6", "pgood_n after delay", pgood_n, 0);
        chk("R2", "run dis_ref_en", dis_ref_en, 0);
    endtask

    task automatic t_standby();
        stby_n = 1'b0;
        cyc(5);
        chk("R3", "stby refbuf_en", refbuf_en, 1);
        chk("R3", "stby out_hiz", out_hiz, 1);
        chk("R3", "stby conv_en", conv_en, 0);
        chk("R3", "stby bias_en", bias_en, 1);
        chk("R6", "stby pgood_n", pgood_n, 1);
        chk("R2", "stby dis_tt_en", dis_tt_en, 0);
        stby_n = 1'b1;
        cyc(5);
        chk("R6", "pgood_n held off on re-entry", pgood_n, 1);
        bring_up("R6");
    endtask

    task automatic t_window();
        uv_flag = 1'b1; cyc(6); uv_flag = 1'b0;
        chk("R11", "uv glitch pgood_n", pgood_n, 0);
        cyc(4);
        chk("R11", "uv glitch pgood_n after", pgood_n, 0);
        uv_flag = 1'b1; cyc(20);
        chk("R11", "uv held pgood_n", pgood_n, 1);
        chk("R11", "uv held conv_en", conv_en, 1);
        uv_flag = 1'b0; cyc(6);
        chk("R11", "uv cleared pgood_n", pgood_n, 0);
        ov_flag = 1'b1; cyc(20);
        chk("R11", "ov held pgood_n", pgood_n, 1);
        chk("R11", "ov held conv_en", conv_en, 1);
        ov_flag = 1'b0; cyc(6);
    endtask

    task automatic t_overcurrent();
        int n, d;
        oc_flag = 1'b1; cyc(16); oc_flag = 1'b0; cyc(4);
        chk("R7", "oc short pulse conv_en", conv_en, 1);
        chk("R7", "oc short pulse pgood_n", pgood_n, 0);
        cyc(4);
        oc_flag = 1'b1; cyc(20);
        chk("R7", "oc early conv_en", conv_en, 1);
        wait_sig(0, 1'b0, 60, n);
        d = 20 + n;
        chk("R7", "oc trip time in window", int'(d >= (OC - 1) * DIV && d <= OC * DIV + 8), 1);
        chk("R7", "oc trip pgood_n", pgood_n, 1);
        oc_flag = 1'b0;
        cyc((RT - 1) * DIV - 8);
        chk("R8", "retry hold conv_en", conv_en, 0);
        chk("R8", "retry out_hiz", out_hiz, 1);
        wait_sig(0, 1'b1, 30, n);
        chk("R8", "retry restart conv_en", conv_en, 1);
        chk("R8", "retry restarts soft start", ss_en, 1);
        bring_up("R8");
    endtask

    task automatic t_short();
        int n;
        sc_flag = 1'b1; cyc(2); sc_flag = 1'b0; cyc(2);
        chk("R9", "sc conv_en", conv_en, 0);
        chk("R9", "sc pgood_n", pgood_n, 1);
        wait_sig(0, 1'b1, 160, n);
        chk("R9", "sc retry length", int'(n >= (RT - 1) * DIV - 6 && n <= RT * DIV + 4), 1);
        bring_up("R9");
    endtask

    task automatic t_thermal();
        int n;
        ot_flag = 1'b1; cyc(4);
        chk("R10", "ot conv_en", conv_en, 0);
        chk("R10", "ot pgood_n", pgood_n, 1);
        cyc(6); ot_flag = 1'b0;
        wait_sig(0, 1'b1, 160, n);
        chk("R10", "ot retry length", int'(n >= (RT - 1) * DIV - 16 && n <= RT * DIV), 1);
        bring_up("R10");
    endtask

    task automatic t_shutdown();
        stby_n = 1'b0; shdn_n = 1'b0;
        cyc(5);
        chk("R1", "shdn over stby dis_tt_en", dis_tt_en, 1);
        chk("R1", "shdn over stby dis_ref_en", dis_ref_en, 1);
        chk("R1", "shdn over stby refbuf_en", refbuf_en, 0);
        chk("R1", "shdn conv_en", conv_en, 0);
        chk("R1", "shdn bias_en", bias_en, 0);
        chk("R1", "shdn pgood_n", pgood_n, 1);
    endtask

    initial begin
        cyc(4);
        rst_n = 1'b1;
        t_reset();
        t_por_gate();
        t_startup();
        t_standby();
        t_window();
        t_overcurrent();
        t_short();
        t_thermal();
        t_shutdown();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule